// File: doc/BRIEF.md
# Round-Robin Result Merger

This block gathers finished results from several execution units of a floating-point datapath and passes them, one per cycle, to a single output port. Each unit presents a result word, an opaque tag, per-lane status flags, a lane-enable mask and a valid signal, and receives a ready signal back. The output side uses the same valid/ready convention. A transfer takes place on a rising clock edge when valid and ready are both high.

When several units hold valid results, a round-robin pointer decides which one wins. While the downstream side stalls, the chosen unit stays selected, so the presented word does not change. The tag travels with its result unchanged. This lets the consumer match results that finish out of order. Each unit's flag vector has five bits: invalid in bit 4, divide-by-zero in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0. Before muxing, the flag vectors of a unit's lanes are ORed together, counting only the lanes whose enable bit is set.

Top module: `rr_result_merge`

## Requirements
- R1: When no unit presents valid, out_valid_o is low and every bit of unit_ready_o is low.
- R2: When at least one unit presents valid, out_valid_o is high and out_data_o equals the result of the selected unit.
- R3: unit_ready_o has at most one bit set. That bit belongs to the selected unit and is set only while out_ready_i is high.
- R4: After a transfer from unit k, the next selection searches upward from unit k+1 and wraps to unit 0.
- R5: A unit never completes two transfers in a row while another unit presents valid. A unit that is the only requester may transfer on consecutive cycles.
- R6: While out_valid_o is high and out_ready_i is low, the selection is frozen. A unit that raises valid with higher search priority does not displace the held unit.
- R7: The round-robin pointer moves only on a completed output transfer. Idle cycles and stalled cycles leave it unchanged.
- R8: out_tag_o equals the tag of the unit whose result is on out_data_o.
- R9: out_flags_o is the OR of the selected unit's lane flag vectors over the lanes whose enable bit is 1. Bit order is invalid (4), divide-by-zero (3), overflow (2), underflow (1), inexact (0). With no lane enabled, the flags are zero.
- R10: After reset, the search starts at unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unit_valid_i | input | NUM_UNITS | Per-unit result valid |
| unit_ready_o | output | NUM_UNITS | Per-unit result accepted |
| unit_data_i | input | NUM_UNITS*DATA_W | Result words, unit i at bits [i*DATA_W +: DATA_W] |
| unit_tag_i | input | NUM_UNITS*TAG_W | Tags, unit i at bits [i*TAG_W +: TAG_W] |
| unit_flags_i | input | NUM_UNITS*LANES*5 | Lane flag vectors, unit i lane l at bits [(i*LANES+l)*5 +: 5] |
| unit_lane_en_i | input | NUM_UNITS*LANES | Lane enables, unit i lane l at bit i*LANES+l |
| out_valid_o | output | 1 | Merged result valid |
| out_ready_i | input | 1 | Downstream accepts |
| out_data_o | output | DATA_W | Merged result word |
| out_tag_o | output | TAG_W | Tag of the merged result |
| out_flags_o | output | 5 | Combined status flags |

## Verification
The bench targets four corner cases.

- **Stall with a new higher-priority requester.** A unit raises valid with higher priority while the output is stalled. A design that re-arbitrates here would swap the presented word and tag in the middle of a handshake.
- **Sole requester on consecutive cycles.** The same unit is the only requester twice in a row. An over-strict fairness rule would leave that unit idle for a cycle.
- **Idle and stall cycles.** A pointer that moves on these cycles would pick the wrong winner in the following row. A reset applied while the pointer sits away from unit 0 shows whether reset returns the search start to unit 0.
- **Lane masks.** Masks of all-on, single-lane and all-off patterns catch flags taken from disabled lanes or placed in the wrong bit order.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

   localparam int unsigned FLAG_W = 5;

   // Ordered from most to least significant bit.
   typedef struct packed {
      logic nv;   // invalid operation
      logic dz;   // divide by zero
      logic of;   // overflow
      logic uf;   // underflow
      logic nx;   // inexact
   } rrm_flags_t;

endpackage

// File: rtl/rrm_flag_reduce.sv
module rrm_flag_reduce
   import rrm_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic [LANES*FLAG_W-1:0] lane_flags_i,
   input  logic [LANES-1:0]        lane_en_i,
   output rrm_flags_t              flags_o
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("rrm_flag_reduce: LANES must be at least 1");
      end

      if (LANES == 1) begin : g_single
         assign flags_o = lane_en_i[0] ? rrm_flags_t'(lane_flags_i) : '0;
      end else begin : g_multi
         always_comb begin
            flags_o = '0;
            for (int l = 0; l < LANES; l++) begin
               if (lane_en_i[l]) begin
                  flags_o = flags_o | rrm_flags_t'(lane_flags_i[l*FLAG_W +: FLAG_W]);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rrm_rr_arbiter.sv
module rrm_rr_arbiter #(
   parameter int unsigned NUM_UNITS = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_UNITS-1:0] req_i,
   input  logic                 accept_i,
   output logic                 any_o,
   output logic [NUM_UNITS-1:0] grant_o
);

   localparam int unsigned IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UNITS - 1);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] held_q;
   logic             lock_q;
   logic [IDX_W-1:0] pick;
   logic             found;
   logic [IDX_W-1:0] sel;

   generate
      if (NUM_UNITS < 1) begin : g_bad_units
         $error("rrm_rr_arbiter: NUM_UNITS must be at least 1");
      end
   endgenerate

   // Scan upward from the pointer, wrapping once.
   always_comb begin
      int cand;
      found = 1'b0;
      pick  = '0;
      for (int off = 0; off < NUM_UNITS; off++) begin
         cand = int'(ptr_q) + off;
         if (cand >= NUM_UNITS) begin
            cand = cand - NUM_UNITS;
         end
         if (!found && req_i[cand]) begin
            found = 1'b1;
            pick  = IDX_W'(cand);
         end
      end
   end

   assign sel   = lock_q ? held_q : pick;
   assign any_o = lock_q | found;

   always_comb begin
      grant_o = '0;
      if (any_o) begin
         grant_o[sel] = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q  <= '0;
         held_q <= '0;
         lock_q <= 1'b0;
      end else if (any_o && accept_i) begin
         lock_q <= 1'b0;
         ptr_q  <= (sel == LAST_IDX) ? '0 : sel + 1'b1;
      end else if (any_o) begin
         lock_q <= 1'b1;
         held_q <= sel;
      end
   end

endmodule

// File: rtl/rr_result_merge.sv
module rr_result_merge
   import rrm_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned LANES     = 2
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [NUM_UNITS-1:0]              unit_valid_i,
   output logic [NUM_UNITS-1:0]              unit_ready_o,
   input  logic [NUM_UNITS*DATA_W-1:0]       unit_data_i,
   input  logic [NUM_UNITS*TAG_W-1:0]        unit_tag_i,
   input  logic [NUM_UNITS*LANES*FLAG_W-1:0] unit_flags_i,
   input  logic [NUM_UNITS*LANES-1:0]        unit_lane_en_i,
   output logic                              out_valid_o,
   input  logic                              out_ready_i,
   output logic [DATA_W-1:0]                 out_data_o,
   output logic [TAG_W-1:0]                  out_tag_o,
   output logic [FLAG_W-1:0]                 out_flags_o
);

   localparam int unsigned UNIT_FLAG_W = LANES * FLAG_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("rr_result_merge: DATA_W must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("rr_result_merge: TAG_W must be at least 1");
      end
   endgenerate

   rrm_flags_t [NUM_UNITS-1:0] unit_red;
   logic [NUM_UNITS-1:0]       grant;
   logic                       any_req;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      rrm_flag_reduce #(
         .LANES(LANES)
      ) i_reduce (
         .lane_flags_i (unit_flags_i[u*UNIT_FLAG_W +: UNIT_FLAG_W]),
         .lane_en_i    (unit_lane_en_i[u*LANES +: LANES]),
         .flags_o      (unit_red[u])
      );
   end

   rrm_rr_arbiter #(
      .NUM_UNITS(NUM_UNITS)
   ) i_arb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (unit_valid_i),
      .accept_i (out_ready_i),
      .any_o    (any_req),
      .grant_o  (grant)
   );

   // One-hot AND-OR selection.
   always_comb begin
      out_data_o  = '0;
      out_tag_o   = '0;
      out_flags_o = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (grant[u]) begin
            out_data_o  = out_data_o  | unit_data_i[u*DATA_W +: DATA_W];
            out_tag_o   = out_tag_o   | unit_tag_i[u*TAG_W +: TAG_W];
            out_flags_o = out_flags_o | unit_red[u];
         end
      end
   end

   assign out_valid_o  = any_req;
   assign unit_ready_o = grant & {NUM_UNITS{out_ready_i}};

endmodule

// File: rtl/rrm_merge_chk.sv
module rrm_merge_chk
   import rrm_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned LANES     = 2
) (
   input logic                              clk_i,
   input logic                              rst_ni,
   input logic [NUM_UNITS-1:0]              unit_valid_i,
   input logic [NUM_UNITS-1:0]              unit_ready_o,
   input logic [NUM_UNITS*DATA_W-1:0]       unit_data_i,
   input logic [NUM_UNITS*TAG_W-1:0]        unit_tag_i,
   input logic [NUM_UNITS*LANES*FLAG_W-1:0] unit_flags_i,
   input logic [NUM_UNITS*LANES-1:0]        unit_lane_en_i,
   input logic                              out_valid_o,
   input logic                              out_ready_i,
   input logic [DATA_W-1:0]                 out_data_o,
   input logic [TAG_W-1:0]                  out_tag_o,
   input logic [FLAG_W-1:0]                 out_flags_o
);

   localparam int unsigned IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

   logic             xfer;
   logic             last_vld_q;
   logic [IDX_W-1:0] last_q;

   assign xfer = out_valid_o && out_ready_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_vld_q <= 1'b0;
         last_q     <= '0;
      end else if (xfer) begin
         last_vld_q <= 1'b1;
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit_ready_o[u]) begin
               last_q <= IDX_W'(u);
            end
         end
      end
   end

   // R1
   no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_valid_i == '0) |-> (!out_valid_o && unit_ready_o == '0));

   // R2
   req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_valid_i != '0) |-> out_valid_o);

   // R3
   ready_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(unit_ready_o));

   // R3
   ready_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_ready_o != '0) |-> xfer);

   // R5
   fair_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_vld_q && xfer && $countones(unit_valid_i) > 1) |-> !unit_ready_o[last_q]);

   // R6
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_tag_o)));

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pass
      // R8
      tag_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         unit_ready_o[u] |->
         (out_tag_o == unit_tag_i[u*TAG_W +: TAG_W] &&
          out_data_o == unit_data_i[u*DATA_W +: DATA_W]));
   end

endmodule

bind rr_result_merge rrm_merge_chk #(
   .NUM_UNITS(NUM_UNITS),
   .DATA_W   (DATA_W),
   .TAG_W    (TAG_W),
   .LANES    (LANES)
) i_merge_chk (.*);

// File: tb/test_rr_result_merge.sv
module test_rr_result_merge;

   localparam int unsigned N  = 4;
   localparam int unsigned DW = 32;
   localparam int unsigned TW = 4;
   localparam int unsigned LN = 2;
   localparam int unsigned ROWS = 16;

   // {req[15:12], valid[11:8], out_ready[7], lane_en[6:5], 2'b0, winner[2:0] (7 = none)}
   localparam logic [15:0] VEC [ROWS] = '{
      {4'd1,  4'b0000, 1'b1, 2'b11, 2'b00, 3'd7},  // R1 idle
      {4'd10, 4'b1111, 1'b1, 2'b11, 2'b00, 3'd0},  // R10 first pick is unit 0
      {4'd4,  4'b1111, 1'b1, 2'b01, 2'b00, 3'd1},  // R4
      {4'd9,  4'b1111, 1'b1, 2'b10, 2'b00, 3'd2},  // R9 lane 1 only
      {4'd4,  4'b1111, 1'b1, 2'b11, 2'b00, 3'd3},  // R4
      {4'd4,  4'b0001, 1'b1, 2'b11, 2'b00, 3'd0},  // R4 wrap
      {4'd5,  4'b0001, 1'b1, 2'b11, 2'b00, 3'd0},  // R5 sole requester repeats
      {4'd4,  4'b0101, 1'b0, 2'b11, 2'b00, 3'd2},  // R4 stall begins
      {4'd6,  4'b0111, 1'b0, 2'b11, 2'b00, 3'd2},  // R6 unit 1 cannot displace
      {4'd6,  4'b0111, 1'b1, 2'b11, 2'b00, 3'd2},  // R6 held unit transfers
      {4'd4,  4'b0011, 1'b1, 2'b11, 2'b00, 3'd0},  // R4
      {4'd5,  4'b0011, 1'b1, 2'b01, 2'b00, 3'd1},  // R5 unit 0 yields
      {4'd3,  4'b1000, 1'b0, 2'b11, 2'b00, 3'd3},  // R3 no ready while stalled
      {4'd9,  4'b1000, 1'b1, 2'b00, 2'b00, 3'd3},  // R9 all lanes off
      {4'd1,  4'b0000, 1'b0, 2'b11, 2'b00, 3'd7},  // R1 idle
      {4'd7,  4'b1001, 1'b1, 2'b11, 2'b00, 3'd0}   // R7 idle left pointer at 0
   };

   logic               clk;
   logic               rst_n;
   logic [N-1:0]       unit_valid;
   logic [N-1:0]       unit_ready;
   logic [N*DW-1:0]    unit_data;
   logic [N*TW-1:0]    unit_tag;
   logic [N*LN*5-1:0]  unit_flags;
   logic [N*LN-1:0]    unit_lane_en;
   logic               out_valid;
   logic               out_ready;
   logic [DW-1:0]      out_data;
   logic [TW-1:0]      out_tag;
   logic [4:0]         out_flags;

   int n_checks;
   int n_fail;

   rr_result_merge #(
      .NUM_UNITS(N), .DATA_W(DW), .TAG_W(TW), .LANES(LN)
   ) i_rr_result_merge (
      .clk_i(clk), .rst_ni(rst_n),
      .unit_valid_i(unit_valid), .unit_ready_o(unit_ready),
      .unit_data_i(unit_data), .unit_tag_i(unit_tag),
      .unit_flags_i(unit_flags), .unit_lane_en_i(unit_lane_en),
      .out_valid_o(out_valid), .out_ready_i(out_ready),
      .out_data_o(out_data), .out_tag_o(out_tag), .out_flags_o(out_flags)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [31:0] data_of(int u);
      return 32'hC0DE_0000 + 32'(u) * 32'h111;
   endfunction

   function automatic logic [TW-1:0] tag_of(int u);
      return TW'(u * 3 + 5);
   endfunction

   // Lane 0 of unit u raises bit u, lane 1 raises the invalid bit (4).
   function automatic logic [4:0] flags_of(int u, logic [1:0] en);
      logic [4:0] f;
      f = '0;
      if (en[0]) f = f | (5'd1 << u);
      if (en[1]) f = f | 5'h10;
      return f;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      n_checks     = 0;
      n_fail       = 0;
      rst_n        = 1'b0;
      unit_valid   = '0;
      out_ready    = 1'b0;
      unit_lane_en = '1;
      for (int u = 0; u < N; u++) begin
         unit_data[u*DW +: DW] = data_of(u);
         unit_tag[u*TW +: TW]  = tag_of(u);
         unit_flags[(u*LN)*5 +: 5]     = 5'd1 << u;
         unit_flags[(u*LN + 1)*5 +: 5] = 5'h10;
      end

      // R1 reset state with no requests
      repeat (2) @(negedge clk);
      check("R1", 32'(out_valid), 32'd0);
      check("R1", 32'(unit_ready), 32'd0);
      rst_n = 1'b1;

      for (int r = 0; r < ROWS; r++) begin
         logic [15:0] v;
         string       tag;
         int          w;
         @(negedge clk);
         v            = VEC[r];
         tag          = $sformatf("R%0d", v[15:12]);
         unit_valid   = v[11:8];
         out_ready    = v[7];
         unit_lane_en = {N{v[6:5]}};
         w            = int'(v[2:0]);
         #2;
         if (w == 7) begin
            check(tag, 32'(out_valid), 32'd0);
            check(tag, 32'(unit_ready), 32'd0);
         end else begin
            check(tag, 32'(out_valid), 32'd1);
            check(tag, 32'(unit_ready), v[7] ? (32'd1 << w) : 32'd0);
            check("R2", out_data, data_of(w));
            check("R8", 32'(out_tag), 32'(tag_of(w)));
            check("R9", 32'(out_flags), 32'(flags_of(w, v[6:5])));
         end
      end

      // R10 reset while the pointer rests on unit 1
      @(negedge clk);
      unit_valid   = 4'b1111;
      out_ready    = 1'b1;
      unit_lane_en = '1;
      rst_n        = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check("R10", 32'(unit_ready), 32'd1);
      check("R10", 32'(out_tag), 32'(tag_of(0)));

      // R7 stall cycles do not advance the pointer: unit 1 follows unit 0
      @(negedge clk);
      out_ready = 1'b0;
      #2;
      check("R7", 32'(out_tag), 32'(tag_of(1)));
      @(negedge clk);
      out_ready = 1'b1;
      #2;
      check("R7", 32'(unit_ready), 32'd2);

      @(negedge clk);
      unit_valid = '0;
      #2;
      check("R1", 32'(out_valid), 32'd0);
      finish_run();
   end

endmodule